// File: doc/BRIEF.md
# Stall-Only Five-Stage Add Pipeline

This block is an in-order, single-issue integer pipeline with five stages: fetch, decode, execute, memory and write-back. It runs a stream of three-register add instructions from a small instruction store that is filled through a load port while reset is held. There is no operand bypass. When an instruction in decode needs a register that an older instruction in execute or memory has not yet written back, fetch and decode hold their state and a bubble goes into execute. The register file writes before it reads, so a consumer may leave decode in the same cycle that its producer is in write-back.

The block is used to measure how many cycles a straight-line program takes under a pure-interlock policy. A retire strobe, a count of retired instructions, a cycle counter and a done flag are visible at the ports. A combinational debug read port lets the final register contents be inspected.

Top module: `pipe5_interlock`

## Requirements
- R1: While reset is low and in the first cycle after it, the cycle count, retired count, retire strobe and done flag are zero. Register i holds the value i.
- R2: An instruction word is 12 bits: destination in bits [11:8], first source in bits [7:4], second source in bits [3:0]. On write-back the destination receives the sum of the two sources, modulo 2^32.
- R3: Register 0 always reads as zero. A write to it is discarded, and a read of it never causes a stall.
- R4: Instructions retire in program order, at most one per cycle. The retire strobe is high for exactly prog_len cycles, and the retired count before each retire equals that instruction's position.
- R5: A decode source that matches the destination of a valid instruction in execute or memory stalls decode. During the stall the program counter and the decode register hold, and execute receives a bubble. No instruction in execute reads a register that a valid instruction in memory or write-back is about to change.
- R6: A producer in write-back satisfies a consumer in decode in the same cycle. A dependence three instructions apart therefore costs no cycle, and one two apart costs one cycle.
- R7: The cycle count runs from the first cycle after reset release through the write-back of the final instruction. The eight-instruction reference sequence with a single adjacent dependence takes 14 cycles.
- R8: After the final write-back, done goes high and stays high. The cycle and retired counts then stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe for the instruction store |
| load_addr | input | PAW | Instruction store write address |
| load_instr | input | 3*RAW | Instruction word to store |
| prog_len | input | PAW+1 | Number of instructions to run (at least 1) |
| dbg_addr | input | RAW | Register index for the debug read |
| dbg_data | output | XLEN | Value of the addressed register |
| retire | output | 1 | High in each write-back cycle |
| retired_cnt | output | PAW+1 | Instructions retired so far |
| cycle_cnt | output | CW | Cycles elapsed since reset release |
| done | output | 1 | Final instruction has retired |

## Verification
The hardest case to reach is a mix of dependence distances inside one program. A stall must end exactly when the producer reaches write-back, and a second hazard can appear right behind it. Random programs draw register fields from only eight registers, so adjacent, two-apart and three-apart dependences, register 0 sources and repeated writers occur often. Directed programs pin down the reference sequence, the distance-three case with no stall, the distance-two case with one stall, and writes to register 0. A bench model computes the decode cycle of each instruction from the stall rule, and from it the total cycle count and the final register values.

// File: rtl/pipe5_interlock.sv
module pipe5_interlock #(
  parameter int XLEN = 32,
  parameter int RAW  = 4,
  parameter int PAW  = 5,
  parameter int CW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PAW-1:0]   load_addr,
  input  logic [3*RAW-1:0] load_instr,
  input  logic [PAW:0]     prog_len,
  input  logic [RAW-1:0]   dbg_addr,
  output logic [XLEN-1:0]  dbg_data,
  output logic             retire,
  output logic [PAW:0]     retired_cnt,
  output logic [CW-1:0]    cycle_cnt,
  output logic             done
);
  localparam int IW    = 3 * RAW;
  localparam int NREG  = 1 << RAW;
  localparam int DEPTH = 1 << PAW;

  logic [IW-1:0]   imem [DEPTH];
  logic [XLEN-1:0] regs [NREG];

  logic [PAW:0]    pc;
  logic            id_v;
  logic [IW-1:0]   id_ins;
  logic            ex_v, mem_v, wb_v;
  logic [RAW-1:0]  ex_rd, ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic [XLEN-1:0] ex_a, ex_b, mem_val, wb_val;

  wire [RAW-1:0] id_rd  = id_ins[3*RAW-1:2*RAW];
  wire [RAW-1:0] id_rs1 = id_ins[2*RAW-1:RAW];
  wire [RAW-1:0] id_rs2 = id_ins[RAW-1:0];
  wire fetch_v = pc < prog_len;

  function automatic logic busy(input logic [RAW-1:0] src);
    return src != '0 && ((ex_v && ex_rd == src) || (mem_v && mem_rd == src));
  endfunction

  function automatic logic [XLEN-1:0] rd_reg(input logic [RAW-1:0] src);
    if (src == '0) return '0;
    if (wb_v && wb_rd == src) return wb_val;
    return regs[src];
  endfunction

  wire stall = id_v && (busy(id_rs1) || busy(id_rs2));
  wire last  = wb_v && retired_cnt == prog_len - 1'b1;

  assign dbg_data = rd_reg(dbg_addr);
  assign retire   = wb_v;

  always_ff @(posedge clk)
    if (load_en) imem[load_addr] <= load_instr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      id_v <= 1'b0;
      id_ins <= '0;
      ex_v <= 1'b0; ex_rd <= '0; ex_rs1 <= '0; ex_rs2 <= '0; ex_a <= '0; ex_b <= '0;
      mem_v <= 1'b0; mem_rd <= '0; mem_val <= '0;
      wb_v <= 1'b0; wb_rd <= '0; wb_val <= '0;
      retired_cnt <= '0;
      cycle_cnt <= '0;
      done <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= XLEN'(i);
    end else begin
      if (!stall) begin
        if (fetch_v) pc <= pc + 1'b1;
        id_v   <= fetch_v;
        id_ins <= imem[pc[PAW-1:0]];
      end
      ex_v   <= id_v && !stall;
      ex_rd  <= id_rd;
      ex_rs1 <= id_rs1;
      ex_rs2 <= id_rs2;
      ex_a   <= rd_reg(id_rs1);
      ex_b   <= rd_reg(id_rs2);
      mem_v   <= ex_v;
      mem_rd  <= ex_rd;
      mem_val <= ex_a + ex_b;
      wb_v   <= mem_v;
      wb_rd  <= mem_rd;
      wb_val <= mem_val;
      if (wb_v && wb_rd != '0) regs[wb_rd] <= wb_val;
      if (wb_v) retired_cnt <= retired_cnt + 1'b1;
      if (!done) cycle_cnt <= cycle_cnt + 1'b1;
      if (last) done <= 1'b1;
    end
  end

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc) && !ex_v); // R5
  AST_NO_RAW_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && mem_v && mem_rd != '0) |-> (ex_rs1 != mem_rd && ex_rs2 != mem_rd)); // R5
  AST_NO_RAW_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && wb_v && wb_rd != '0) |-> (ex_rs1 != wb_rd && ex_rs2 != wb_rd)); // R6
  AST_RETIRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> retired_cnt < prog_len); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(cycle_cnt) && $stable(retired_cnt)); // R8
  always_comb AST_R0_ZERO: assert (!rst_n || dbg_addr != '0 || dbg_data == '0); // R3
endmodule

// File: tb/pipe5_interlock_tb.sv
module pipe5_interlock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [11:0] load_instr = '0;
  logic [5:0]  prog_len = 6'd1;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        retire;
  logic [5:0]  retired_cnt;
  logic [15:0] cycle_cnt;
  logic        done;

  int errors = 0;
  int checks = 0;
  logic [11:0] prog [32];
  logic [31:0] exp_reg [16];
  int exp_cyc;

  always #4 clk = ~clk;

  pipe5_interlock u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ins(input int rd, input int a, input int b);
    return {rd[3:0], a[3:0], b[3:0]};
  endfunction

  task automatic model(input int n);
    int d [32];
    int lastw [16];
    for (int i = 0; i < 16; i++) begin exp_reg[i] = i; lastw[i] = -1; end
    for (int i = 0; i < n; i++) begin
      int rd = prog[i][11:8];
      int s1 = prog[i][7:4];
      int s2 = prog[i][3:0];
      d[i] = (i == 0) ? 2 : d[i-1] + 1;
      if (s1 != 0 && lastw[s1] >= 0 && d[lastw[s1]] + 3 > d[i]) d[i] = d[lastw[s1]] + 3;
      if (s2 != 0 && lastw[s2] >= 0 && d[lastw[s2]] + 3 > d[i]) d[i] = d[lastw[s2]] + 3;
      if (rd != 0) begin
        exp_reg[rd] = exp_reg[s1] + exp_reg[s2];
        lastw[rd] = i;
      end
    end
    exp_cyc = d[n-1] + 3;
  endtask

  task automatic run(input int n, input string tag);
    int cyc = 0;
    int seen = 0;
    bit order_ok = 1'b1;
    logic [15:0] held;
    @(negedge clk);
    rst_n = 1'b0;
    prog_len = 6'(n);
    for (int i = 0; i < n; i++) begin
      load_en = 1'b1; load_addr = 5'(i); load_instr = prog[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    model(n);
    dbg_addr = 4'd5;
    #1;
    chk(cycle_cnt == 0 && retired_cnt == 0 && !done && !retire && dbg_data == 5,
        {tag, " R1 reset state"}, cycle_cnt, 0);
    rst_n = 1'b1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (retire) begin
        if (retired_cnt != 6'(seen)) order_ok = 1'b0;
        seen++;
      end
    end
    chk(done, {tag, " R8 done reached"}, done, 1);
    chk(cycle_cnt == 16'(exp_cyc), {tag, " R5 R6 R7 cycle count"}, cycle_cnt, exp_cyc);
    chk(cyc == exp_cyc, {tag, " R7 bench cycle count"}, cyc, exp_cyc);
    chk(seen == n && order_ok, {tag, " R4 retire sequence"}, seen, n);
    held = cycle_cnt;
    repeat (3) @(negedge clk);
    chk(done && cycle_cnt == held && retired_cnt == 6'(n), {tag, " R8 counters frozen"}, cycle_cnt, held);
    for (int r = 0; r < 16; r++) begin
      dbg_addr = 4'(r);
      #1;
      chk(dbg_data == exp_reg[r], {tag, (r == 0) ? " R3 r0 zero" : " R2 register value"}, dbg_data, exp_reg[r]);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(negedge clk);
    // reference sequence: R7 expects 14 cycles
    prog[0] = ins(1,3,5); prog[1] = ins(9,2,3); prog[2] = ins(6,3,3); prog[3] = ins(3,4,3);
    prog[4] = ins(4,7,1); prog[5] = ins(5,7,4); prog[6] = ins(9,3,6); prog[7] = ins(2,7,6);
    run(8, "ref");
    chk(exp_cyc == 14, "R7 reference total", exp_cyc, 14);
    // R6 distance three: no stall, 8 cycles
    prog[0] = ins(1,2,3); prog[1] = ins(5,0,0); prog[2] = ins(6,0,0); prog[3] = ins(7,1,1);
    run(4, "dist3");
    chk(exp_cyc == 8, "R6 distance three", exp_cyc, 8);
    // R6 distance two: one stall
    prog[0] = ins(1,2,3); prog[1] = ins(5,0,0); prog[2] = ins(4,1,2);
    run(3, "dist2");
    chk(exp_cyc == 8, "R6 distance two", exp_cyc, 8);
    // R3 write to r0 discarded, r0 source never stalls
    prog[0] = ins(0,7,7); prog[1] = ins(8,0,0); prog[2] = ins(9,0,3);
    run(3, "r0");
    chk(exp_cyc == 7, "R3 r0 no stall", exp_cyc, 7);
    // single instruction
    prog[0] = ins(15,14,13);
    run(1, "one");
    for (int t = 0; t < 20; t++) begin
      int n = 1 + int'($urandom_range(31, 0));
      for (int i = 0; i < n; i++)
        prog[i] = ins($urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(7, 0));
      run(n, $sformatf("rnd%0d", t));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule